// File: doc/BRIEF.md
# Synchronized Two-Ratio Clock Divider

This block turns one input clock into two slower clocks that share their rising edges. The fast output runs at half the input rate. The slow output runs at a quarter or a sixth of the input rate, chosen by a ratio select input. A single shared counter produces both outputs, so they step together. Every rising edge of the slow output is therefore also a rising edge of the fast one. A phase marker flags the input cycle in which both outputs rise together. Downstream logic can use it to line up work with the common edge.

An active-low run enable is captured on the falling edge of the input clock. The dividers can therefore only start or stop while the input clock is low. An active-high master reset acts asynchronously and puts every instance into the same known state. Several dividers released from one reset then run in step.

Top module: `ratio_clock_divider`

## Requirements
- R1: While running, `divHalf` inverts on every rising edge of `clkIn`, giving a period of 2 input cycles with a 50% duty cycle.
- R2: While running, `divSlow` has a period of 4 input cycles when the active ratio is 0 and 6 when it is 1. It is high for the first half of each period (2 or 3 cycles) and low for the second half.
- R3: Every rising edge of `divSlow` falls on the same input edge as a rising edge of `divHalf`.
- R4: With `enableN` captured low, the dividers advance on each rising input edge. With it captured high, `divHalf` and `divSlow` keep their levels and `phaseMark` is low.
- R5: `enableN` is sampled only on the falling edge of `clkIn`. A change made while `clkIn` is high acts from the next rising edge. A change made while `clkIn` is low acts from the second rising edge after it.
- R6: `phaseMark` is high for exactly the one input cycle that starts at a coincident rising edge of `divHalf` and `divSlow`, and low at all other times. Its pulses are 2 or 3 `divHalf` periods apart.
- R7: A change on `ratioSel` takes effect only at the next rising edge of `divSlow`. The period in progress completes at the old length.
- R8: `rstMaster` high forces `divHalf`, `divSlow` and `phaseMark` low at once, independent of the clock, and clears the captured enable. After release, nothing moves until a falling edge captures `enableN` low. The first enabled rising edge then raises `divHalf`, `divSlow` and `phaseMark` together, with the ratio taken from `ratioSel` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| rstMaster | input | 1 | Asynchronous master reset, active high |
| enableN | input | 1 | Run enable, active low, sampled on the falling edge |
| ratioSel | input | 1 | Slow ratio select: 0 divides by 4, 1 divides by 6 |
| divHalf | output | 1 | Input clock divided by 2 |
| divSlow | output | 1 | Input clock divided by 4 or 6 |
| phaseMark | output | 1 | One-cycle marker of a shared rising edge |

## Verification
The hardest case to reach from the ports is an enable edge placed on either side of the falling clock edge. The two placements must give results exactly one input cycle apart. The stimulus moves `enableN` shortly after a rising edge, while the clock is high, and again just after a falling edge, while it is low. It then checks in which following cycle `divHalf` first moves. A second hard case is a ratio change in the middle of a slow period. The bench flips `ratioSel` at several counter positions and expects the old period to run out before the new length appears.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
  // strobes from control to the counting datapath
  typedef struct packed {
    logic advance;   // count on this rising edge
    logic restart;   // counter wraps to zero on this edge
    logic useAlt;    // alternate (longer) slow ratio active
  } divStrobe_t;
endpackage

// File: rtl/ratio_div_ctrl.sv
module ratio_div_ctrl
  import ratio_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstMaster,
  input  logic       enableN,
  input  logic       ratioSel,
  input  logic       atLast,
  output divStrobe_t strobe
);
  logic runFlag;
  logic useAltQ;

  // enable captured while the clock is low so no runt internal pulse
  always_ff @(negedge clk or posedge rstMaster) begin
    if (rstMaster) runFlag <= 1'b0;
    else           runFlag <= ~enableN;
  end

  // ratio is adopted only when the counter wraps
  always_ff @(posedge clk or posedge rstMaster) begin
    if (rstMaster)              useAltQ <= 1'b0;
    else if (runFlag && atLast) useAltQ <= ratioSel;
  end

  always_comb begin
    strobe.advance = runFlag;
    strobe.restart = runFlag & atLast;
    strobe.useAlt  = useAltQ;
  end
endmodule

// File: rtl/ratio_div_path.sv
module ratio_div_path
  import ratio_div_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 6
) (
  input  logic       clk,
  input  logic       rstMaster,
  input  divStrobe_t strobe,
  output logic       atLast,
  output logic       divHalf,
  output logic       divSlow,
  output logic       phaseMark
);
  localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW   = $clog2(MAXD);
  localparam logic [CW-1:0] LAST_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(DIV_B - 1);
  localparam logic [CW-1:0] HALF_A = CW'(DIV_A / 2);
  localparam logic [CW-1:0] HALF_B = CW'(DIV_B / 2);

  logic [CW-1:0] cnt, cntNext, lastIdx, halfLen;
  logic          halfQ, slowQ, phaseQ;

  always_comb begin
    lastIdx = strobe.useAlt ? LAST_B : LAST_A;
    halfLen = strobe.useAlt ? HALF_B : HALF_A;
    // >= also recovers any out-of-range power-up count
    atLast  = (cnt >= lastIdx);
    if (!strobe.advance)     cntNext = cnt;
    else if (strobe.restart) cntNext = '0;
    else                     cntNext = cnt + 1'b1;
  end

  // reset parks the counter at its top so the first advance wraps
  always_ff @(posedge clk or posedge rstMaster) begin
    if (rstMaster) begin
      cnt    <= '1;
      halfQ  <= 1'b0;
      slowQ  <= 1'b0;
      phaseQ <= 1'b0;
    end else if (strobe.advance) begin
      cnt    <= cntNext;
      halfQ  <= ~cntNext[0];
      slowQ  <= strobe.restart ? 1'b1 : (cntNext < halfLen);
      phaseQ <= strobe.restart;
    end else begin
      phaseQ <= 1'b0;
    end
  end

  assign divHalf   = halfQ;
  assign divSlow   = slowQ;
  assign phaseMark = phaseQ;
endmodule

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider
  import ratio_div_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 6
) (
  input  logic clkIn,
  input  logic rstMaster,
  input  logic enableN,
  input  logic ratioSel,
  output logic divHalf,
  output logic divSlow,
  output logic phaseMark
);
  divStrobe_t strobe;
  logic       atLast;
  logic       runLive;

  assign runLive = strobe.advance;

  ratio_div_ctrl u_ctrl (
    .clk       (clkIn),
    .rstMaster (rstMaster),
    .enableN   (enableN),
    .ratioSel  (ratioSel),
    .atLast    (atLast),
    .strobe    (strobe)
  );

  ratio_div_path #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_path (
    .clk       (clkIn),
    .rstMaster (rstMaster),
    .strobe    (strobe),
    .atLast    (atLast),
    .divHalf   (divHalf),
    .divSlow   (divSlow),
    .phaseMark (phaseMark)
  );
endmodule

// File: rtl/ratio_clock_divider_chk.sv
module ratio_clock_divider_chk (
  input logic clkIn,
  input logic rstMaster,
  input logic runLive,
  input logic divHalf,
  input logic divSlow,
  input logic phaseMark
);
  // R1: fast output inverts on each running edge
  p_half_toggles_r1: assert property (@(posedge clkIn) disable iff (rstMaster)
    runLive |=> (divHalf != $past(divHalf)));

  // R3: slow rise always shares the edge with a fast rise
  p_rise_aligned_r3: assert property (@(posedge clkIn) disable iff (rstMaster)
    $rose(divSlow) |-> $rose(divHalf));

  // R4: stopped dividers hold their levels
  p_hold_when_off_r4: assert property (@(posedge clkIn) disable iff (rstMaster)
    !runLive |=> ($stable(divHalf) && $stable(divSlow) && !phaseMark));

  // R6: marker only on a coincident rise
  p_mark_on_rise_r6: assert property (@(posedge clkIn) disable iff (rstMaster)
    phaseMark |-> ($rose(divSlow) && $rose(divHalf)));

  // R6: marker never lasts two cycles
  p_mark_single_r6: assert property (@(posedge clkIn) disable iff (rstMaster)
    phaseMark |=> !phaseMark);

  // R8: reset holds everything low
  p_reset_low_r8: assert property (@(posedge clkIn)
    rstMaster |-> (!divHalf && !divSlow && !phaseMark));
endmodule

bind ratio_clock_divider ratio_clock_divider_chk u_chk (
  .clkIn     (clkIn),
  .rstMaster (rstMaster),
  .runLive   (runLive),
  .divHalf   (divHalf),
  .divSlow   (divSlow),
  .phaseMark (phaseMark)
);

// File: tb/tb_ratio_clock_divider.sv
`timescale 1ns/1ps
module tb_ratio_clock_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enableN = 1'b1;
  logic ratioSel = 1'b0;
  logic divHalf, divSlow, phaseMark;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk; // 125 MHz

  ratio_clock_divider dut (
    .clkIn(clk), .rstMaster(rst), .enableN(enableN), .ratioSel(ratioSel),
    .divHalf(divHalf), .divSlow(divSlow), .phaseMark(phaseMark)
  );

  typedef struct { logic h; logic s; logic p; } exp_t;
  exp_t q[$];

  task automatic check(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  // reference model, written from the requirements; pushes expected items
  logic mRun = 1'b0;
  int   mIdx = -1;
  int   mPer = 4;
  exp_t mExp = '{1'b0, 1'b0, 1'b0};

  always @(negedge clk) mRun = rst ? 1'b0 : !enableN;  // R5 falling-edge capture

  always @(posedge clk) begin
    if (rst) begin
      mIdx = -1; mPer = 4; mRun = 1'b0;
      mExp = '{1'b0, 1'b0, 1'b0};              // R8
    end else if (mRun) begin
      if (mIdx < 0 || mIdx == mPer - 1) begin
        mIdx = 0; mPer = ratioSel ? 6 : 4;     // R7 ratio adopted at slow rise
        mExp.p = 1'b1;
      end else begin
        mIdx++; mExp.p = 1'b0;
      end
      mExp.h = (mIdx % 2 == 0);                // R1
      mExp.s = (mIdx < mPer / 2);              // R2
    end else begin
      mExp.p = 1'b0;                           // R4 hold
    end
    q.push_back(mExp);
  end

  // monitor: pops expectations and compares away from the edge
  logic prevH = 1'b0, prevS = 1'b0;
  int   halfRises = 0;
  bit   seenMark = 0;
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("R1", "divHalf", divHalf, e.h);
      check("R2/R7", "divSlow", divSlow, e.s);
      check("R6", "phaseMark", phaseMark, e.p);
    end
    if (rst) begin
      halfRises = 0; seenMark = 0;
    end else begin
      if (divSlow && !prevS) check("R3", "divHalf rises with divSlow", divHalf && !prevH, 1'b1);
      if (divHalf && !prevH) halfRises++;
      if (phaseMark) begin
        if (seenMark) check("R6", "marker spacing of 2 or 3", (halfRises == 3 || halfRises == 4), 1'b1);
        seenMark = 1; halfRises = 1;
      end
    end
    prevH = divHalf; prevS = divSlow;
  end

  task automatic atHigh(int n); repeat (n) @(posedge clk); #1; endtask
  task automatic atLow(int n);  repeat (n) @(posedge clk); #5; endtask

  initial begin : watchdog
    #800000;
    nFails++;
    $display("FAIL R4 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic h0;
    atLow(3);
    check("R8", "divHalf in reset", divHalf, 1'b0);
    check("R8", "divSlow in reset", divSlow, 1'b0);
    rst = 1'b0;
    atLow(3);
    check("R8", "idle after release", divHalf, 1'b0);
    enableN = 1'b0;                 // set while clock low
    atLow(24);
    ratioSel = 1'b1; atHigh(1);     // R7 mid-period change
    atHigh(37);
    ratioSel = 1'b0; atLow(2);      // R7 change at another position
    atHigh(29);
    // R4 stop while high, hold for a while
    enableN = 1'b1; atHigh(10);
    // R5 enable while clock high: acts on the next rising edge
    h0 = divHalf;
    enableN = 1'b0;
    @(posedge clk); #2;
    check("R5", "advance after high-phase enable", divHalf, ~h0);
    atHigh(5);
    enableN = 1'b1; atHigh(6);
    // R5 enable while clock low: first rising edge still holds
    @(posedge clk); #5;
    h0 = divHalf;
    enableN = 1'b0;
    @(posedge clk); #2;
    check("R5", "hold after low-phase enable", divHalf, h0);
    @(posedge clk); #2;
    check("R5", "advance one edge later", divHalf, ~h0);
    ratioSel = 1'b1;
    atHigh(20);
    // R8 asynchronous reset mid-run
    @(posedge clk); #5;
    rst = 1'b1; #1;
    check("R8", "divHalf cleared at once", divHalf, 1'b0);
    check("R8", "divSlow cleared at once", divSlow, 1'b0);
    check("R8", "phaseMark cleared at once", phaseMark, 1'b0);
    atLow(3);
    rst = 1'b0;
    atHigh(30);
    ratioSel = 1'b0; atLow(3);
    atHigh(25);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule